// File: doc/BRIEF.md
# Selectable-Ratio Expansion Bus Clock Generator

This block makes the clock for a slow expansion bus out of a fast system clock. A three-bit field taken from a configuration byte picks one of eight settings. Six of them divide the fast clock by an even or odd integer ratio. The other two pass a separately generated fixed reference clock straight through. Register decoding and the generation of the reference clock sit outside the block. The configuration byte arrives already registered in the fast clock domain.

A new setting is never applied in the middle of an output cycle. The divider finishes its current period and only then loads the new ratio. A move between the divided clock and the reference clock goes through a break-before-make clock multiplexer, with a synchronizer on each side, so the bus clock never carries a runt pulse. When the setting in effect changes, a one-cycle strobe in the fast clock domain tells the surrounding logic.

Top module: `busClkGen`

## Requirements
- R1: Select code 0 (configuration bits 2:0 equal to 000) makes the bus clock follow the reference clock, with the same period and the same high time.
- R2: Select codes 1, 2, 3, 4, 5 and 6 give a bus clock period of 4, 5, 6, 8, 10 and 12 fast clock cycles respectively.
- R3: Select code 7 is illegal and behaves exactly like code 0. Moving between 0 and 7 raises no change strobe.
- R4: Configuration bits above bit 2 have no effect on the bus clock period or on the change strobe.
- R5: For a ratio N, the bus clock is high for floor(N/2) fast cycles and low for the rest. Ratio 5 therefore splits 2 high and 3 low.
- R6: A new divide ratio takes effect only at the end of the current output period. No high or low pulse is ever shorter than two fast clock cycles.
- R7: A change between the divided source and the reference source is glitch-free. The two sources are never enabled at the same time, and no pulse shorter than two fast cycles appears.
- R8: The change strobe is high for exactly one fast clock cycle each time the effective setting changes, and at no other time.
- R9: While reset is held, the bus clock and the change strobe are low. After reset the reference clock is selected without raising a change strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock that the divider counts |
| refClk | input | 1 | Fixed reference clock passed through for codes 0 and 7 |
| rst_n | input | 1 | Asynchronous active-low reset for both clock domains |
| cfgReg | input | CFG_W (8) | Configuration byte; bits 2:0 select the setting |
| busClk | output | 1 | Generated expansion bus clock |
| ratioChanged | output | 1 | One fast-cycle strobe when the applied setting changes |

## Verification
Two events can fall on the same fast clock edge: a configuration write landing on the last count of a period, and the divider wrap that loads the new ratio and raises the change strobe. The bench forces this case with randomly timed writes and with two writes one cycle apart. A continuous pulse-width monitor on the bus clock judges the result, along with an exact count of strobe pulses (one or two in the back-to-back case), followed by a period and high-time measurement of the final setting.

// File: rtl/busClkPkg.sv
`timescale 1ns/1ps
package busClkPkg;
  localparam int SEL_W = 3;
  localparam int CNT_W = 4;

  typedef logic [SEL_W-1:0] selT;
  typedef logic [CNT_W-1:0] cntT;

  // strobes from control to the divider datapath
  typedef struct packed {
    cntT  lastCnt;   // terminal count of current period
    cntT  highCnt;   // cycles the divided clock stays high
    logic useRef;    // pass the reference clock instead
  } divStrbT;

  function automatic cntT ratioOf(selT s);
    case (s)
      selT'(2): ratioOf = cntT'(5);
      selT'(3): ratioOf = cntT'(6);
      selT'(4): ratioOf = cntT'(8);
      selT'(5): ratioOf = cntT'(10);
      selT'(6): ratioOf = cntT'(12);
      default:  ratioOf = cntT'(4);   // code 1, and the divider idle rate in reference mode
    endcase
  endfunction

  // the illegal all-ones code folds onto the reference code
  function automatic selT normSel(selT s);
    normSel = (s == '1) ? '0 : s;
  endfunction

  function automatic logic isRef(selT s);
    isRef = (s == '0);
  endfunction
endpackage

// File: rtl/busClkCtrl.sv
`timescale 1ns/1ps
module busClkCtrl
  import busClkPkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  selT     selIn,
  input  logic    periodEnd,
  input  logic    srcSettled,
  output divStrbT strb,
  output logic    ratioChanged
);
  selT  curSel;
  selT  pendSel;
  logic srcSwitch;
  logic applyNew;

  assign pendSel   = normSel(selIn);
  assign srcSwitch = isRef(pendSel) != isRef(curSel);
  // a source change waits until the previous hand-over has completed
  assign applyNew  = periodEnd && (pendSel != curSel) && (!srcSwitch || srcSettled);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      curSel       <= '0;
      ratioChanged <= 1'b0;
    end else begin
      ratioChanged <= applyNew;
      if (applyNew) curSel <= pendSel;
    end
  end

  assign strb.lastCnt = ratioOf(curSel) - cntT'(1);
  assign strb.highCnt = ratioOf(curSel) >> 1;
  assign strb.useRef  = isRef(curSel);

  p_legal_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    curSel != '1);
  p_hold_mid_period_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !periodEnd |=> $stable(curSel));
  p_strobe_on_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ratioChanged |-> (curSel != $past(curSel)));
  p_strobe_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ratioChanged |=> !ratioChanged);
endmodule

// File: rtl/busClkDiv.sv
`timescale 1ns/1ps
module busClkDiv
  import busClkPkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  divStrbT strb,
  output logic    divClk,
  output logic    periodEnd
);
  cntT cnt;
  cntT cntInc;

  assign cntInc    = cnt + cntT'(1);
  assign periodEnd = (cnt == strb.lastCnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      divClk <= 1'b0;
    end else if (periodEnd) begin
      cnt    <= '0;
      divClk <= 1'b1;
    end else begin
      cnt    <= cntInc;
      divClk <= (cntInc < strb.highCnt);
    end
  end

  p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= strb.lastCnt);
  p_rise_after_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    periodEnd |=> divClk);
  p_low_at_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    periodEnd |-> !divClk);
endmodule

// File: rtl/busClkMux.sv
`timescale 1ns/1ps
module busClkMux (
  input  logic clk,
  input  logic refClk,
  input  logic rst_n,
  input  logic useRef,
  input  logic divClk,
  output logic busClk,
  output logic srcSettled
);
  logic divS1, divS2, enDiv;
  logic refS1, refS2, enRef;
  logic refOnA, refOnB;

  // fast domain: request, then enable changed only while divClk is low
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      divS1  <= 1'b0;
      divS2  <= 1'b0;
      refOnA <= 1'b0;
      refOnB <= 1'b0;
    end else begin
      divS1  <= !useRef && !enRef;
      divS2  <= divS1;
      refOnA <= enRef;
      refOnB <= refOnA;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)       enDiv <= 1'b0;
    else if (!divClk) enDiv <= divS2;
  end

  // reference domain: request, then enable on the falling edge
  always_ff @(posedge refClk or negedge rst_n) begin
    if (!rst_n) begin
      refS1 <= 1'b0;
      refS2 <= 1'b0;
    end else begin
      refS1 <= useRef && !enDiv;
      refS2 <= refS1;
    end
  end

  always_ff @(negedge refClk or negedge rst_n) begin
    if (!rst_n) enRef <= 1'b0;
    else        enRef <= refS2;
  end

  assign busClk     = (divClk && enDiv) || (refClk && enRef);
  assign srcSettled = useRef ? refOnB : enDiv;

  p_one_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(enDiv && enRef));
endmodule

// File: rtl/busClkGen.sv
`timescale 1ns/1ps
module busClkGen
  import busClkPkg::*;
#(
  parameter int CFG_W = 8
) (
  input  logic             clk,
  input  logic             refClk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfgReg,
  output logic             busClk,
  output logic             ratioChanged
);
  divStrbT strb;
  logic    divClk;
  logic    periodEnd;
  logic    srcSettled;
  logic    unusedCfgHi;

  generate
    if (CFG_W > SEL_W) begin : g_hi
      assign unusedCfgHi = ^cfgReg[CFG_W-1:SEL_W];
    end else begin : g_nohi
      assign unusedCfgHi = 1'b0;
    end
  endgenerate

  busClkCtrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .selIn(cfgReg[SEL_W-1:0]),
    .periodEnd(periodEnd), .srcSettled(srcSettled),
    .strb(strb), .ratioChanged(ratioChanged)
  );

  busClkDiv u_div (
    .clk(clk), .rst_n(rst_n), .strb(strb),
    .divClk(divClk), .periodEnd(periodEnd)
  );

  busClkMux u_mux (
    .clk(clk), .refClk(refClk), .rst_n(rst_n), .useRef(strb.useRef),
    .divClk(divClk), .busClk(busClk), .srcSettled(srcSettled)
  );
endmodule

// File: tb/busClkGen_bench.sv
`timescale 1ns/1ps
module busClkGen_bench;
  localparam real CLK_P = 5.0;
  localparam real REF_P = 140.0;

  logic       clk = 1'b0;
  logic       refClk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] cfgReg = 8'h00;
  logic       busClk;
  logic       ratioChanged;

  int checks = 0;
  int errors = 0;
  int chgCount = 0;
  int chgRun = 0;
  int wideStrobe = 0;
  int shortPulses = 0;
  int curEff = 0;
  bit monOn = 1'b0;
  realtime lastEdge = 0;

  always #(CLK_P/2) clk = ~clk;
  always #(REF_P/2) refClk = ~refClk;

  busClkGen u_busClkGen (
    .clk(clk), .refClk(refClk), .rst_n(rst_n), .cfgReg(cfgReg),
    .busClk(busClk), .ratioChanged(ratioChanged)
  );

  // strobe monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n && ratioChanged) begin
      chgCount++;
      chgRun++;
      if (chgRun > 1) wideStrobe++;
    end else chgRun = 0;
  end

  // pulse-width monitor: nothing narrower than two fast cycles
  always @(busClk) begin
    if (monOn && ($realtime - lastEdge) < (2.0*CLK_P - 0.1)) shortPulses++;
    lastEdge = $realtime;
  end

  function automatic int effOf(input logic [7:0] v);
    return (v[2:0] == 3'd7) ? 0 : int'(v[2:0]);
  endfunction

  function automatic int ratioFor(input int e);
    case (e)
      1: return 4;  2: return 5;  3: return 6;
      4: return 8;  5: return 10; 6: return 12;
      default: return 0;
    endcase
  endfunction

  function automatic real expPeriod(input int e);
    return (e == 0) ? REF_P : ratioFor(e) * CLK_P;
  endfunction

  function automatic real expHigh(input int e);
    return (e == 0) ? REF_P/2 : (ratioFor(e) / 2) * CLK_P;
  endfunction

  task automatic chk(input bit ok, input string req, input real act, input real exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0.3f expected %0.3f", req, act, exp);
    end
  endtask

  task automatic measureAndCheck(input logic [7:0] v, input int chgLo, input int chgHi,
                                 input int chgBefore, input int shortBefore, input int prevEff);
    realtime t0, t1, t2;
    int e = effOf(v);
    string tagP;
    repeat (240) @(posedge clk);
    @(posedge busClk) t0 = $realtime;
    @(negedge busClk) t1 = $realtime;
    @(posedge busClk) t2 = $realtime;
    if (v[7:3] != 5'd0) tagP = "R4";
    else if (v[2:0] == 3'd7) tagP = "R3";
    else if (e == 0) tagP = "R1";
    else tagP = "R2";
    chk((t2 - t0) > expPeriod(e) - 0.01 && (t2 - t0) < expPeriod(e) + 0.01,
        tagP, t2 - t0, expPeriod(e));
    chk((t1 - t0) > expHigh(e) - 0.01 && (t1 - t0) < expHigh(e) + 0.01,
        "R5", t1 - t0, expHigh(e));
    chk((chgCount - chgBefore) >= chgLo && (chgCount - chgBefore) <= chgHi,
        "R8", real'(chgCount - chgBefore), real'(chgHi));
    chk(shortPulses == shortBefore, ((e == 0) != (prevEff == 0)) ? "R7" : "R6",
        real'(shortPulses - shortBefore), 0.0);
    curEff = e;
  endtask

  task automatic runCode(input logic [7:0] v);
    int cb = chgCount;
    int sb = shortPulses;
    int pe = curEff;
    int n = (effOf(v) != pe) ? 1 : 0;
    @(negedge clk) cfgReg = v;
    measureAndCheck(v, n, n, cb, sb, pe);
  endtask

  // two writes one cycle apart: the first may or may not be applied
  task automatic runBackToBack(input logic [7:0] a, input logic [7:0] b);
    int cb = chgCount;
    int sb = shortPulses;
    int pe = curEff;
    @(negedge clk) cfgReg = a;
    @(negedge clk) cfgReg = b;
    measureAndCheck(b, 1, 2, cb, sb, pe);
  endtask

  initial begin : watchdog
    #(200000 * CLK_P);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'h5EED_0A1C));
    #20;
    // R9: outputs quiet while reset is held
    chk(busClk == 1'b0, "R9", real'(busClk), 0.0);
    chk(ratioChanged == 1'b0, "R9", real'(ratioChanged), 0.0);
    @(negedge clk) rst_n = 1'b1;
    monOn = 1'b1;
    // R9 / R1: reference selected after reset, no strobe
    runCode(8'h00);
    runCode(8'h07);          // R3: illegal code, same as 0, no strobe
    for (int c = 1; c <= 6; c++) runCode(8'(c));   // R2 all ratios
    runCode(8'hF9);          // R4: code 1 with upper bits set
    runCode(8'h2A);          // R4: code 2 with upper bits set
    runCode(8'h07);          // R3/R7: divided to reference via illegal code
    runCode(8'h00);          // R3: no strobe between 7 and 0
    runCode(8'h01);          // R7: reference back to divided
    runBackToBack(8'h06, 8'h02);  // R6: write on or near a wrap
    for (int i = 0; i < 14; i++) runCode(8'($urandom()));
    chk(wideStrobe == 0, "R8", real'(wideStrobe), 0.0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule